// File: doc/BRIEF.md
# Private Interrupt State Register Bank

This block keeps the per-processor state of 32 private interrupt lines. Lines 0 to 15 are software-generated and lines 16 to 31 are peripheral. It holds an enable bitmap, a pending bitmap and an active bitmap. It also holds a group bitmap, a group-modifier word, a word of access-control fields (2 bits for each software-generated line) and an edge/level trigger flag for each peripheral line. Software reaches each of the three state bitmaps through two word addresses. A write to the set address turns bits on. A write to the clear address turns bits off. A read from either address returns the same bitmap.

Every bus access carries a secure attribute. While the global security-disable input is low, a non-secure access may only see or change the bits of lines whose group bit is 1. All other bits read as zero and ignore writes. When the security-disable input is high, or when the access is secure, every bit is reachable.

The block drives a combined pending view to the prioritisation logic that follows it. That view is the pending latch ORed with the live input level of every line configured as level-sensitive.

Top module: `pirq_bank`

## Requirements
- R1: After reset, the enable, pending, active, group, group-modifier, access-control, trigger and wake state are all zero, `pend_view` is zero and `rsp_valid` is low.
- R2: Every request produces exactly one response, with `rsp_valid` high in the cycle after the request. The register index map is: 0 wake, 1 group, 2 enable-set, 3 enable-clear, 4 pending-set, 5 pending-clear, 6 active-set, 7 active-clear, 8 trigger word for lines 0-15, 9 trigger word for lines 16-31, 10 group modifier, 11 access control. Any index of 12 or more returns `rsp_err`=1 with data zero and changes no state.
- R3: The permitted-bit mask is the group bitmap when the access is non-secure and `sec_disable` is 0. In every other case the mask is all ones. Bits outside the mask are not changed by set or clear writes and read as zero.
- R4: A write to a set index ORs (data AND mask) into its bitmap. A write to a clear index removes (data AND mask) from the bitmap. A read of either index returns (bitmap AND mask).
- R5: A pending read returns (pending latch OR (input level AND NOT edge flag)) AND mask. `pend_view` carries the same merge without the mask.
- R6: The group register reads as zero and ignores writes when the access is non-secure and `sec_disable` is 0.
- R7: The group-modifier and access-control registers read as zero and ignore writes unless the access is secure and `sec_disable` is 0.
- R8: A trigger word read places the edge flag of each line in the odd bit (2i+1) of its 2-bit field, and every even bit reads as zero. Lines 0-15 always read as level-sensitive.
- R9: Writes to the trigger word for lines 0-15 are ignored. A write to the trigger word for lines 16-31 loads bit 2i+1 into the edge flag of line 16+i, only where the mask allows, and ignores even bits.
- R10: In the wake register, bit 0 is the writable sleep request. Bit 1 reads as the asleep status and always equals bit 0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word register index |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Secure attribute of the access |
| sec_disable | input | 1 | Global security disable |
| irq_level | input | 32 | Live input level of each line |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Unmapped index |
| pend_view | output | 32 | Pending latch merged with level-sensitive inputs |

## Verification
The same set and clear words are driven once as secure accesses and once as non-secure accesses, with a group bitmap that splits the lines into two halves. A mismatch therefore separates a missing mask, an inverted mask and a mask applied only on one alias. The pending readback is tried with latched bits and live levels, first with the level lines configured as level-sensitive and then as edge-sensitive, which shows whether the merge honours the trigger flag. Trigger writes use odd-only data, even-only data, a non-secure all-ones word and a write to the lower word, which tells a correct odd-bit unpacking apart from a shifted one or an unmasked one.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int REG_AW = 5;

    // Word index map; order is fixed by software drivers.
    typedef enum logic [REG_AW-1:0] {
        RI_WAKE   = 5'd0,
        RI_GROUP  = 5'd1,
        RI_EN_SET = 5'd2,
        RI_EN_CLR = 5'd3,
        RI_PD_SET = 5'd4,
        RI_PD_CLR = 5'd5,
        RI_AC_SET = 5'd6,
        RI_AC_CLR = 5'd7,
        RI_CFG_LO = 5'd8,
        RI_CFG_HI = 5'd9,
        RI_GMOD   = 5'd10,
        RI_NSCTL  = 5'd11
    } reg_idx_e;

    // Index of each set/clear bitmap inside the bitmap array.
    localparam int BM_EN   = 0;
    localparam int BM_PEND = 1;
    localparam int BM_ACT  = 2;
    localparam int NUM_MAPS = 3;

endpackage

// File: rtl/pirq_access_mask.sv
module pirq_access_mask #(
    parameter int NUM_IRQ = 32
) (
    input  logic               sec_disable,
    input  logic               secure,
    input  logic [NUM_IRQ-1:0] group_bits,
    output logic [NUM_IRQ-1:0] mask,
    output logic               ns_restricted,
    output logic               priv_access
);

    always_comb begin
        ns_restricted = !sec_disable && !secure;
        priv_access   = secure && !sec_disable;
        mask          = ns_restricted ? group_bits : {NUM_IRQ{1'b1}};
    end

endmodule

// File: rtl/pirq_setclr.sv
module pirq_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] mask,
    output logic [W-1:0] bits_q
);

    logic [W-1:0] bits_d;
    logic [W-1:0] eff;

    always_comb begin
        eff    = wdata & mask;
        bits_d = bits_q;
        if (set_we) bits_d = bits_d | eff;
        if (clr_we) bits_d = bits_d & ~eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((bits_q & $past(wdata & mask)) == $past(wdata & mask))); // R4

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((bits_q & $past(wdata & mask)) == '0)); // R4

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we || clr_we) |=> (((bits_q ^ $past(bits_q)) & ~$past(mask)) == '0)); // R3

endmodule

// File: rtl/pirq_cfg_codec.sv
module pirq_cfg_codec #(
    parameter int NUM_IRQ = 32,
    localparam int HALF   = NUM_IRQ / 2
) (
    input  logic [HALF-1:0]    edge_half,
    input  logic [HALF-1:0]    mask_half,
    input  logic [NUM_IRQ-1:0] wdata,
    output logic [NUM_IRQ-1:0] rd_word,
    output logic [HALF-1:0]    wr_half
);

    // Each line owns a 2-bit field; only its odd bit carries the edge flag.
    for (genvar i = 0; i < HALF; i++) begin : g_field
        assign rd_word[2*i]   = 1'b0;
        assign rd_word[2*i+1] = edge_half[i] & mask_half[i];
        assign wr_half[i]     = wdata[2*i+1];
    end

endmodule

// File: rtl/pirq_bank.sv
module pirq_bank
    import pirq_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int HALF   = NUM_IRQ / 2,
    localparam int AW     = REG_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [NUM_IRQ-1:0] req_wdata,
    input  logic               req_secure,
    input  logic               sec_disable,
    input  logic [NUM_IRQ-1:0] irq_level,
    output logic               rsp_valid,
    output logic [NUM_IRQ-1:0] rsp_rdata,
    output logic               rsp_err,
    output logic [NUM_IRQ-1:0] pend_view
);

    localparam logic [NUM_IRQ-1:0] EVEN_BITS = {HALF{2'b01}};

    typedef struct packed {
        logic [NUM_IRQ-1:0] group;
        logic [NUM_IRQ-1:0] gmod;
        logic [NUM_IRQ-1:0] nsctl;
        logic [HALF-1:0]    edge_hi;
        logic               wake;
        logic               rsp_valid;
        logic               rsp_err;
        logic [NUM_IRQ-1:0] rsp_rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_IRQ-1:0]  mask;
    logic                ns_restricted;
    logic                priv_access;
    logic [NUM_MAPS-1:0] set_we, clr_we;
    logic [NUM_IRQ-1:0]  bm_q [NUM_MAPS];
    logic [NUM_IRQ-1:0]  edge_full;
    logic [NUM_IRQ-1:0]  pend_merge;
    logic [NUM_IRQ-1:0]  cfg_hi_rd;
    logic [HALF-1:0]     cfg_hi_wr;

    pirq_access_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
        .sec_disable   (sec_disable),
        .secure        (req_secure),
        .group_bits    (st_q.group),
        .mask          (mask),
        .ns_restricted (ns_restricted),
        .priv_access   (priv_access)
    );

    for (genvar k = 0; k < NUM_MAPS; k++) begin : g_map
        pirq_setclr #(.W(NUM_IRQ)) u_bm (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_we[k]),
            .clr_we (clr_we[k]),
            .wdata  (req_wdata),
            .mask   (mask),
            .bits_q (bm_q[k])
        );
    end

    pirq_cfg_codec #(.NUM_IRQ(NUM_IRQ)) u_cfg (
        .edge_half (st_q.edge_hi),
        .mask_half (mask[NUM_IRQ-1:HALF]),
        .wdata     (req_wdata),
        .rd_word   (cfg_hi_rd),
        .wr_half   (cfg_hi_wr)
    );

    // Software-generated lines never become edge flagged in this bank.
    assign edge_full  = {st_q.edge_hi, {HALF{1'b0}}};
    assign pend_merge = bm_q[BM_PEND] | (irq_level & ~edge_full);
    assign pend_view  = pend_merge;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_rdata = '0;
        set_we         = '0;
        clr_we         = '0;
        if (req_valid) begin
            case (req_addr)
                RI_WAKE: begin
                    if (req_write) st_d.wake = req_wdata[0];
                    else st_d.rsp_rdata = {{(NUM_IRQ-2){1'b0}}, st_q.wake, st_q.wake};
                end
                RI_GROUP: begin
                    if (!ns_restricted) begin
                        if (req_write) st_d.group = req_wdata;
                        else           st_d.rsp_rdata = st_q.group;
                    end
                end
                RI_EN_SET, RI_EN_CLR: begin
                    if (req_write) begin
                        set_we[BM_EN] = (req_addr == RI_EN_SET);
                        clr_we[BM_EN] = (req_addr == RI_EN_CLR);
                    end else st_d.rsp_rdata = bm_q[BM_EN] & mask;
                end
                RI_PD_SET, RI_PD_CLR: begin
                    if (req_write) begin
                        set_we[BM_PEND] = (req_addr == RI_PD_SET);
                        clr_we[BM_PEND] = (req_addr == RI_PD_CLR);
                    end else st_d.rsp_rdata = pend_merge & mask;
                end
                RI_AC_SET, RI_AC_CLR: begin
                    if (req_write) begin
                        set_we[BM_ACT] = (req_addr == RI_AC_SET);
                        clr_we[BM_ACT] = (req_addr == RI_AC_CLR);
                    end else st_d.rsp_rdata = bm_q[BM_ACT] & mask;
                end
                RI_CFG_LO: begin
                    // Lower lines are fixed level flagged: reads zero, writes dropped.
                    st_d.rsp_rdata = '0;
                end
                RI_CFG_HI: begin
                    if (req_write)
                        st_d.edge_hi = (st_q.edge_hi & ~mask[NUM_IRQ-1:HALF])
                                     | (cfg_hi_wr & mask[NUM_IRQ-1:HALF]);
                    else st_d.rsp_rdata = cfg_hi_rd;
                end
                RI_GMOD: begin
                    if (priv_access) begin
                        if (req_write) st_d.gmod = req_wdata;
                        else           st_d.rsp_rdata = st_q.gmod;
                    end
                end
                RI_NSCTL: begin
                    if (priv_access) begin
                        if (req_write) st_d.nsctl = req_wdata;
                        else           st_d.rsp_rdata = st_q.nsctl;
                    end
                end
                default: st_d.rsp_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;
    assign rsp_err   = st_q.rsp_err;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid && rst_n)); // R2

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R2

    AST_GROUP_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && req_addr == RI_GROUP && !req_secure && !sec_disable)
        |-> (rsp_rdata == '0)); // R6

    AST_PRIV_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && (req_addr == RI_GMOD || req_addr == RI_NSCTL)
              && !(req_secure && !sec_disable))
        |-> (rsp_rdata == '0)); // R7

    AST_CFG_EVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && (req_addr == RI_CFG_LO || req_addr == RI_CFG_HI))
        |-> ((rsp_rdata & EVEN_BITS) == '0)); // R8

    AST_CFG_LO_WI: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_addr == RI_CFG_LO)
        |-> $stable(pend_view) || !$stable(irq_level)); // R9

endmodule

// File: tb/tb_pirq_bank.sv
`timescale 1ns/1ps
module tb_pirq_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_secure, sec_disable;
    logic [4:0]  req_addr;
    logic [31:0] req_wdata, irq_level;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata, pend_view;

    int checks = 0;
    int errors = 0;

    bit          chk_q[$];
    logic [31:0] dat_q[$];
    bit          err_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pirq_bank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
        .sec_disable(sec_disable), .irq_level(irq_level), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pend_view(pend_view)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: called at a negedge, returns at the next negedge.
    task automatic acc(input bit wr, input int addr, input logic [31:0] wd, input bit sec,
                       input bit chk, input logic [31:0] exp, input bit experr, input string tag);
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = addr[4:0];
        req_wdata  = wd;
        req_secure = sec;
        chk_q.push_back(chk);
        dat_q.push_back(exp);
        err_q.push_back(experr);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [31:0] wd, input bit sec, input string tag);
        acc(1'b1, addr, wd, sec, 1'b0, 32'h0, 1'b0, tag);
    endtask

    task automatic rd(input int addr, input bit sec, input logic [31:0] exp, input string tag);
        acc(1'b0, addr, 32'h0, sec, 1'b1, exp, 1'b0, tag);
    endtask

    // Monitor: pops expected items as responses appear.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (chk_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected response actual=%08h expected=none", rsp_rdata);
            end else begin
                bit c; logic [31:0] d; bit e; string t;
                c = chk_q.pop_front(); d = dat_q.pop_front();
                e = err_q.pop_front(); t = tag_q.pop_front();
                check({t, " err"}, {31'b0, rsp_err}, {31'b0, e});
                if (c) check(t, rsp_rdata, d);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam int WAKE = 0, GRP = 1, ENS = 2, ENC = 3, PDS = 4, PDC = 5;
    localparam int ACS = 6, ACC = 7, CFL = 8, CFH = 9, GMD = 10, NSC = 11;

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_secure = 1'b0; sec_disable = 1'b0; irq_level = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pend_view", pend_view, 32'h0);
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        rd(ENS, 1, 32'h0, "R1 enable");
        rd(WAKE, 1, 32'h0, "R1 wake");
        rd(CFH, 1, 32'h0, "R1 trigger");

        // Group split: lines 0-15 reachable by non-secure accesses.
        wr(GRP, 32'h0000FFFF, 1, "R6 wr");
        rd(GRP, 1, 32'h0000FFFF, "R6 secure read");
        rd(GRP, 0, 32'h0, "R6 ns read zero");
        wr(GRP, 32'hFFFFFFFF, 0, "R6 ns wr");
        rd(GRP, 1, 32'h0000FFFF, "R6 ns write ignored");

        wr(ENS, 32'hFFFFFFFF, 0, "R3 ns set");
        rd(ENC, 1, 32'h0000FFFF, "R3 ns set masked");
        wr(ENS, 32'hF0000000, 1, "R4 s set");
        rd(ENS, 0, 32'h0000FFFF, "R3 ns read masked");
        wr(ENC, 32'hF00000FF, 0, "R3 ns clear");
        rd(ENS, 1, 32'hF000FF00, "R4 clear alias");

        sec_disable = 1'b1;
        rd(ENS, 0, 32'hF000FF00, "R3 sec disabled full mask");
        wr(GMD, 32'h00001234, 0, "R7 wr");
        sec_disable = 1'b0;
        rd(GMD, 1, 32'h0, "R7 gmod ns write ignored");
        wr(GMD, 32'hA5A5A5A5, 1, "R7 wr");
        rd(GMD, 1, 32'hA5A5A5A5, "R7 gmod secure");
        rd(GMD, 0, 32'h0, "R7 gmod ns read zero");
        wr(NSC, 32'h00000055, 1, "R7 wr");
        rd(NSC, 1, 32'h00000055, "R7 nsctl secure");
        sec_disable = 1'b1;
        rd(NSC, 1, 32'h0, "R7 nsctl sec disabled");
        wr(NSC, 32'hFFFFFFFF, 1, "R7 wr");
        sec_disable = 1'b0;
        rd(NSC, 1, 32'h00000055, "R7 nsctl write ignored");

        wr(PDS, 32'h00000003, 1, "R4 pend set");
        irq_level = 32'h00030010;
        rd(PDS, 1, 32'h00030013, "R5 level merge");
        check("R5 pend_view", pend_view, 32'h00030013);
        wr(CFH, 32'h0000000A, 1, "R9 wr");
        rd(CFH, 1, 32'h0000000A, "R8 odd bits");
        rd(PDC, 1, 32'h00000013, "R5 edge lines drop level");
        check("R5 pend_view edge", pend_view, 32'h00000013);
        rd(CFL, 1, 32'h0, "R8 low word");
        wr(CFL, 32'hFFFFFFFF, 1, "R9 wr");
        rd(CFL, 1, 32'h0, "R9 low word ignored");
        rd(PDS, 1, 32'h00000013, "R9 low word no effect");
        wr(CFH, 32'hFFFFFFFF, 0, "R9 ns wr");
        rd(CFH, 1, 32'h0000000A, "R9 ns masked");
        wr(CFH, 32'h00000005, 1, "R9 even wr");
        rd(CFH, 1, 32'h0, "R9 even bits ignored");
        rd(PDS, 1, 32'h00030013, "R5 level back");
        rd(PDC, 0, 32'h00000013, "R3 ns pend masked");
        wr(PDC, 32'h00000001, 1, "R4 pend clear");
        rd(PDS, 1, 32'h00030012, "R4 pend cleared");

        wr(ACS, 32'h80000001, 1, "R4 act set");
        wr(ACC, 32'hFFFFFFFF, 0, "R3 ns act clear");
        rd(ACS, 1, 32'h80000000, "R3 act masked clear");

        wr(WAKE, 32'h00000001, 0, "R10 wr");
        rd(WAKE, 0, 32'h00000003, "R10 asleep mirrors");
        wr(WAKE, 32'hFFFFFFFE, 1, "R10 wr");
        rd(WAKE, 1, 32'h0, "R10 awake");
        wr(WAKE, 32'hFFFFFFFF, 1, "R10 wr");
        rd(WAKE, 1, 32'h00000003, "R10 only bit0 writable");

        acc(1'b1, 12, 32'hFFFFFFFF, 1, 1'b1, 32'h0, 1'b1, "R2 unmapped write");
        acc(1'b0, 31, 32'h0, 1, 1'b1, 32'h0, 1'b1, "R2 unmapped read");
        rd(ENS, 1, 32'hF000FF00, "R2 no state change");

        repeat (4) @(negedge clk);
        check("R2 all responses seen", chk_q.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule